// File: doc/BRIEF.md
# Electrode Polarization Guard

This controller watches a stream of demodulated in-phase and quadrature results from a conductivity probe and decides whether the electrode interface is drifting into polarization. For each accepted result it grades the ratio |Q|/|I| against three programmable limits (warn, action, fault). The ratio is graded without a divider: the grading multiplies the limits, which are unsigned fixed point with 8 fractional bits, by |I|. The grade drives a small recovery engine. The engine moves to another excitation frequency, stops excitation for a recovery window, or lowers the drive amplitude, in that escalating order. If the ratio stays high after the last step, or recovery takes too long, it latches an electrode fault.

The controller also owns the excitation duty cycle: excitation is switched on for a measure window and off for a rest window, in turns. Results are taken into account only while excitation is on. Every recovery step and every fault is written as a packed record into a small log FIFO. The record holds the cause, the step taken, the frequency and amplitude in force afterwards, and the grade of the first result that followed. Firmware drains the FIFO. Computing I/Q and the conductivity value itself happens outside this block.

Top module: `pol_guard`

## Requirements
- R1: A result's grade is the highest limit that the ratio strictly exceeds: grade 3 if |Q|·256 > fault·|I|, else 2 if |Q|·256 > action·|I|, else 1 if |Q|·256 > warn·|I|, else 0. I and Q are two's complement and their magnitudes are used. A ratio exactly equal to a limit does not exceed it.
- R2: A result with I equal to zero is graded 3, whatever Q is.
- R3: After reset, exc_en is high for MEAS_LEN cycles and then low for REST_LEN cycles, and this repeats. A result presented while exc_en is low is ignored.
- R4: A grade-1 result only sets health to 1 (warn) and changes neither frequency nor amplitude. The warn indication clears only after two consecutive grade-0 results.
- R5: Grade-2 results escalate through the steps hop, pause, reduce and then fault. A result of grade 0 or 1 in between resets the escalation, so the next grade-2 result hops again. While escalation is under way or a pause is running, health reads 2.
- R6: A hop advances freq_idx by one, modulo NFREQ.
- R7: A pause drives exc_en low for exactly PAUSE_LEN cycles. A fresh measure window then starts.
- R8: A reduce lowers amp_code by one and saturates at 0. amp_code starts at AMP_INIT and never rises.
- R9: A grade-3 result enters fault at once. In fault, health is 3 and exc_en is 0, all results are ignored, and the state holds until reset.
- R10: Once a pause ends, a recovery timer starts. If no result of grade 0 or 1 arrives within RECOV_MAX cycles, the block enters fault.
- R11: A log record is {cause[1:0], step[1:0], freq_idx, amp_code, grade[1:0]}, most significant field first. The causes are 1 = action limit, 2 = fault limit and 3 = recovery timeout. The steps are 0 = hop, 1 = pause, 2 = reduce and 3 = fault. A hop, pause or reduce record is written when the next accepted result arrives, and it carries that result's grade. A fault record is written one cycle after fault is entered, and it carries the grade of the last accepted result.
- R12: The log holds LOG_DEPTH records. log_data shows the oldest record, and log_rd removes it. A record written while the log is full is dropped, and log_ovf is then set and stays set until reset.
- R13: After reset, health is 0 (0 ok, 1 warn, 2 recovering, 3 fault), freq_idx is 0, amp_code is AMP_INIT, exc_en is 1, log_empty is 1 and log_ovf is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | A new I/Q result is present |
| res_i | input | IQ_W | In-phase result, two's complement |
| res_q | input | IQ_W | Quadrature result, two's complement |
| th_warn | input | TH_W | Warn limit, unsigned, 8 fractional bits |
| th_act | input | TH_W | Action limit, unsigned, 8 fractional bits |
| th_fault | input | TH_W | Fault limit, unsigned, 8 fractional bits |
| freq_idx | output | FI_W | Selected excitation frequency |
| amp_code | output | AMP_W | Excitation amplitude code |
| exc_en | output | 1 | Excitation on |
| health | output | 2 | 0 ok, 1 warn, 2 recovering, 3 fault |
| log_rd | input | 1 | Remove the oldest log record |
| log_data | output | 6+FI_W+AMP_W | Oldest log record |
| log_empty | output | 1 | Log holds no record |
| log_ovf | output | 1 | A record was dropped |

## Verification
The bench places a ratio exactly on the action limit and exactly on the fault limit. A comparator that used >= instead of > would hop or fault there. It sends a zero I, which a design that divides or forgets the guard would grade as clean. Clean results are placed between grade-2 results, so a design that never resets its escalation would pause where a hop is expected. Three hops in a row check the frequency wrap. The bench counts how long the pause and the duty windows last, so off-by-one counters show up as wrong lengths. It also reads back the exact log records after an escalation chain, after a timeout and after an overflow. A design that logged the pre-action state, or failed to drop the record written into a full log, would not match.

// File: rtl/pol_guard.sv
module pol_guard #(
  parameter int IQ_W      = 16,
  parameter int TH_W      = 16,
  parameter int NFREQ     = 3,
  parameter int AMP_W     = 3,
  parameter int AMP_INIT  = 7,
  parameter int MEAS_LEN  = 8,
  parameter int REST_LEN  = 4,
  parameter int PAUSE_LEN = 6,
  parameter int RECOV_MAX = 20,
  parameter int LOG_DEPTH = 4,
  localparam int FI_W = (NFREQ > 1) ? $clog2(NFREQ) : 1,
  localparam int LW   = 6 + FI_W + AMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_valid,
  input  logic [IQ_W-1:0]  res_i,
  input  logic [IQ_W-1:0]  res_q,
  input  logic [TH_W-1:0]  th_warn,
  input  logic [TH_W-1:0]  th_act,
  input  logic [TH_W-1:0]  th_fault,
  output logic [FI_W-1:0]  freq_idx,
  output logic [AMP_W-1:0] amp_code,
  output logic             exc_en,
  output logic [1:0]       health,
  input  logic             log_rd,
  output logic [LW-1:0]    log_data,
  output logic             log_empty,
  output logic             log_ovf
);
  localparam int PW   = IQ_W + TH_W;
  localparam int CMAX = (MEAS_LEN > REST_LEN) ? ((MEAS_LEN > PAUSE_LEN) ? MEAS_LEN : PAUSE_LEN)
                                              : ((REST_LEN > PAUSE_LEN) ? REST_LEN : PAUSE_LEN);
  localparam int CW   = $clog2(CMAX + 1);
  localparam int RW   = $clog2(RECOV_MAX + 1);
  localparam int LA   = $clog2(LOG_DEPTH);

  typedef enum logic [1:0] {S_RUN, S_PAUSE, S_FAULT} st_t;

  st_t             st;
  logic            meas;
  logic [CW-1:0]   cnt;
  logic [RW-1:0]   rtmr;
  logic            rt_on;
  logic [1:0]      esc;
  logic            warn_f, ok1;
  logic            pend_v, flog;
  logic [1:0]      pend_r, pend_a, flt_r, last_lvl;

  logic [IQ_W-1:0] ai, aq;
  logic [PW-1:0]   qs, pw, pa, pf;
  logic [1:0]      lvl;
  logic            acc, tmo;

  assign ai  = res_i[IQ_W-1] ? (~res_i + 1'b1) : res_i;
  assign aq  = res_q[IQ_W-1] ? (~res_q + 1'b1) : res_q;
  assign qs  = {{(PW-IQ_W-8){1'b0}}, aq, 8'd0};
  assign pw  = PW'(th_warn)  * PW'(ai);
  assign pa  = PW'(th_act)   * PW'(ai);
  assign pf  = PW'(th_fault) * PW'(ai);
  assign lvl = (ai == '0 || qs > pf) ? 2'd3 : (qs > pa) ? 2'd2 : (qs > pw) ? 2'd1 : 2'd0;

  assign exc_en = (st == S_RUN) && meas;
  assign acc    = res_valid && exc_en;
  assign tmo    = rt_on && (rtmr >= RW'(RECOV_MAX - 1));
  assign health = (st == S_FAULT) ? 2'd3 :
                  (st == S_PAUSE || esc != 2'd0) ? 2'd2 :
                  warn_f ? 2'd1 : 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_RUN;  meas <= 1'b1;  cnt <= '0;
      rtmr <= '0;  rt_on <= 1'b0;  esc <= 2'd0;
      warn_f <= 1'b0;  ok1 <= 1'b0;
      pend_v <= 1'b0;  pend_r <= 2'd0;  pend_a <= 2'd0;
      flog <= 1'b0;  flt_r <= 2'd0;  last_lvl <= 2'd0;
      freq_idx <= '0;
      amp_code <= AMP_W'(AMP_INIT);
    end else begin
      case (st)
        S_RUN: begin
          if (meas) begin
            if (cnt == CW'(MEAS_LEN - 1)) begin meas <= 1'b0; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end else begin
            if (cnt == CW'(REST_LEN - 1)) begin meas <= 1'b1; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
          if (rt_on && !tmo) rtmr <= rtmr + 1'b1;

          if (acc) begin
            last_lvl <= lvl;
            pend_v   <= 1'b0;
            if (lvl != 2'd0) begin
              warn_f <= 1'b1;
              ok1    <= 1'b0;
            end else if (ok1) begin
              warn_f <= 1'b0;
              ok1    <= 1'b0;
            end else if (warn_f) begin
              ok1    <= 1'b1;
            end

            if (lvl == 2'd3) begin
              st <= S_FAULT;  flog <= 1'b1;  flt_r <= 2'd2;
            end else if (lvl == 2'd2) begin
              case (esc)
                2'd0: begin
                  freq_idx <= (freq_idx == FI_W'(NFREQ - 1)) ? '0 : freq_idx + 1'b1;
                  esc <= 2'd1;  pend_v <= 1'b1;  pend_r <= 2'd1;  pend_a <= 2'd0;
                end
                2'd1: begin
                  st <= S_PAUSE;  cnt <= '0;  rt_on <= 1'b0;
                  esc <= 2'd2;  pend_v <= 1'b1;  pend_r <= 2'd1;  pend_a <= 2'd1;
                end
                2'd2: begin
                  if (amp_code != '0) amp_code <= amp_code - 1'b1;
                  esc <= 2'd3;  pend_v <= 1'b1;  pend_r <= 2'd1;  pend_a <= 2'd2;
                end
                default: begin
                  st <= S_FAULT;  flog <= 1'b1;  flt_r <= 2'd1;
                end
              endcase
            end else begin
              esc   <= 2'd0;
              rt_on <= 1'b0;
            end
          end else if (tmo) begin
            st <= S_FAULT;  flog <= 1'b1;  flt_r <= 2'd3;
          end
        end
        S_PAUSE: begin
          if (cnt == CW'(PAUSE_LEN - 1)) begin
            st <= S_RUN;  meas <= 1'b1;  cnt <= '0;
            rt_on <= 1'b1;  rtmr <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: flog <= 1'b0;
      endcase
    end
  end

  logic [LW-1:0] mem [LOG_DEPTH];
  logic [LA:0]   wp, rp;
  logic          push, full;
  logic [LW-1:0] word;

  assign push = (acc && pend_v) || (st == S_FAULT && flog);
  assign word = (st == S_FAULT) ? {flt_r, 2'd3, freq_idx, amp_code, last_lvl}
                                : {pend_r, pend_a, freq_idx, amp_code, lvl};
  assign full      = (wp[LA] != rp[LA]) && (wp[LA-1:0] == rp[LA-1:0]);
  assign log_empty = (wp == rp);
  assign log_data  = mem[rp[LA-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[LA-1:0]] <= word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;  rp <= '0;  log_ovf <= 1'b0;
    end else begin
      if (push) begin
        if (full) log_ovf <= 1'b1;
        else      wp <= wp + 1'b1;
      end
      if (log_rd && !log_empty) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/pol_guard_chk.sv
module pol_guard_chk #(
  parameter int NFREQ = 3,
  parameter int FI_W  = 2,
  parameter int AMP_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [FI_W-1:0]  freq_idx,
  input logic [AMP_W-1:0] amp_code,
  input logic             exc_en,
  input logic [1:0]       health,
  input logic             log_ovf
);
  assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    health == 2'd3 |=> health == 2'd3);

  assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    health == 2'd3 |-> !exc_en);

  assert_freq_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    freq_idx < FI_W'(NFREQ));

  assert_hop_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    freq_idx != $past(freq_idx) |-> health == 2'd2);

  assert_amp_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    amp_code != $past(amp_code) |-> ({1'b0, amp_code} + 1'b1) == {1'b0, $past(amp_code)});

  assert_ovf_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    log_ovf |=> log_ovf);
endmodule

bind pol_guard pol_guard_chk #(.NFREQ(NFREQ), .FI_W(FI_W), .AMP_W(AMP_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .freq_idx(freq_idx), .amp_code(amp_code),
  .exc_en(exc_en), .health(health), .log_ovf(log_ovf)
);

// File: tb/pol_guard_tb_top.sv
`timescale 1ns/1ps
module pol_guard_tb_top;
  localparam int MEAS_LEN = 8, REST_LEN = 4, PAUSE_LEN = 6, RECOV_MAX = 20;

  logic        clk = 1'b0, rst_n = 1'b0, res_valid = 1'b0, log_rd = 1'b0;
  logic [15:0] res_i = '0, res_q = '0;
  logic [1:0]  freq_idx;
  logic [2:0]  amp_code;
  logic        exc_en, log_empty, log_ovf;
  logic [1:0]  health;
  logic [10:0] log_data;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  pol_guard #(.MEAS_LEN(MEAS_LEN), .REST_LEN(REST_LEN), .PAUSE_LEN(PAUSE_LEN),
              .RECOV_MAX(RECOV_MAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_i(res_i), .res_q(res_q),
    .th_warn(16'd64), .th_act(16'd128), .th_fault(16'd256),
    .freq_idx(freq_idx), .amp_code(amp_code), .exc_en(exc_en), .health(health),
    .log_rd(log_rd), .log_data(log_data), .log_empty(log_empty), .log_ovf(log_ovf));

  function automatic int mk(int r, int a, int f, int am, int l);
    return (r << 9) | (a << 7) | (f << 5) | (am << 2) | l;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; res_valid = 1'b0; log_rd = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic send(int i, int q);
    @(negedge clk);
    while (!exc_en) @(negedge clk);
    res_i = 16'(i); res_q = 16'(q); res_valid = 1'b1;
    @(negedge clk) res_valid = 1'b0;
  endtask

  task automatic pop(string req, int exp);
    chk({req, " not empty"}, log_empty, 0);
    chk({req, " record"}, log_data, exp);
    log_rd = 1'b1;
    @(negedge clk) log_rd = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R13 health", health, 0);
    chk("R13 freq", freq_idx, 0);
    chk("R13 amp", amp_code, 7);
    chk("R13 exc_en", exc_en, 1);
    chk("R13 empty", log_empty, 1);
    chk("R13 ovf", log_ovf, 0);
  endtask

  task automatic t_duty();
    int hi = 0, lo = 0;
    do_reset();
    while (exc_en) begin hi++; @(negedge clk); end
    while (!exc_en) begin lo++; @(negedge clk); end
    chk("R3 measure length", hi, MEAS_LEN);
    chk("R3 rest length", lo, REST_LEN);
    while (exc_en) @(negedge clk);
    res_i = 16'd1000; res_q = 16'd600; res_valid = 1'b1;
    @(negedge clk) res_valid = 1'b0;
    chk("R3 ignored in rest freq", freq_idx, 0);
    chk("R3 ignored in rest health", health, 0);
  endtask

  task automatic t_warn();
    do_reset();
    send(1000, 500);
    chk("R1 equal to action is warn", health, 1);
    chk("R1 equal to action no hop", freq_idx, 0);
    send(1000, 300);
    chk("R4 warn health", health, 1);
    chk("R4 warn no action", freq_idx, 0);
    send(1000, 0);
    chk("R4 one clean keeps warn", health, 1);
    send(1000, 0);
    chk("R4 two clean clear", health, 0);
    send(-1000, -300);
    chk("R1 negative magnitudes", health, 1);
  endtask

  task automatic t_escalate();
    int lo = 0;
    do_reset();
    send(1000, 600);
    chk("R6 hop freq", freq_idx, 1);
    chk("R5 recovering", health, 2);
    send(1000, 600);
    while (!exc_en) begin lo++; @(negedge clk); end
    chk("R7 pause length", lo, PAUSE_LEN);
    send(1000, 600);
    chk("R8 reduce amp", amp_code, 6);
    chk("R5 reduce keeps freq", freq_idx, 1);
    send(1000, 600);
    chk("R5 escalate to fault", health, 3);
    chk("R9 fault exc off", exc_en, 0);
    @(negedge clk);
    pop("R11 hop", mk(1, 0, 1, 7, 2));
    pop("R11 pause", mk(1, 1, 1, 7, 2));
    pop("R11 reduce", mk(1, 2, 1, 6, 2));
    pop("R11 fault", mk(1, 3, 1, 6, 2));
    chk("R12 drained", log_empty, 1);
  endtask

  task automatic t_fault();
    do_reset();
    send(1000, 1000);
    chk("R1 equal to fault is action", health, 2);
    chk("R1 equal to fault hops", freq_idx, 1);
    do_reset();
    send(1000, 1200);
    chk("R9 fault health", health, 3);
    chk("R9 fault exc", exc_en, 0);
    @(negedge clk);
    pop("R11 fault limit", mk(2, 3, 0, 7, 3));
    res_i = 16'd1000; res_q = 16'd600; res_valid = 1'b1;
    @(negedge clk) res_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 ignored in fault freq", freq_idx, 0);
    chk("R9 ignored in fault log", log_empty, 1);
    chk("R9 fault held", health, 3);
    do_reset();
    send(0, 0);
    chk("R2 zero I fault", health, 3);
  endtask

  task automatic t_recover();
    do_reset();
    send(1000, 600);
    send(1000, 600);
    send(1000, 0);
    chk("R5 clean resets escalation", health, 1);
    send(1000, 0);
    chk("R4 cleared after recovery", health, 0);
    send(1000, 600);
    chk("R5 hop again after clean", freq_idx, 2);
    chk("R5 hop no pause", exc_en | (health == 2 ? 1 : 0), 1);
    send(1000, 0);
    send(1000, 0);
    send(1000, 600);
    chk("R6 wrap to zero", freq_idx, 0);
  endtask

  task automatic t_timeout();
    do_reset();
    send(1000, 600);
    send(1000, 600);
    @(negedge clk);
    while (!exc_en) @(negedge clk);
    repeat (10) @(negedge clk);
    chk("R10 before timeout", health, 2);
    repeat (15) @(negedge clk);
    chk("R10 timeout fault", health, 3);
    pop("R11 hop before timeout", mk(1, 0, 1, 7, 2));
    pop("R11 timeout", mk(3, 3, 1, 7, 2));
  endtask

  task automatic t_overflow();
    do_reset();
    for (int k = 0; k < 5; k++) begin
      send(1000, 600);
      send(1000, 0);
    end
    chk("R12 overflow set", log_ovf, 1);
    pop("R12 first", mk(1, 0, 1, 7, 0));
    pop("R12 second", mk(1, 0, 2, 7, 0));
    pop("R12 third", mk(1, 0, 0, 7, 0));
    pop("R12 fourth", mk(1, 0, 1, 7, 0));
    chk("R12 fifth dropped", log_empty, 1);
    chk("R12 overflow sticky", log_ovf, 1);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_duty();
    t_warn();
    t_escalate();
    t_fault();
    t_recover();
    t_timeout();
    t_overflow();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule